// File: doc/BRIEF.md
# Paged Memory Segment Decoder

This block turns a processor address bus, an 8-bit page register and the read and write strobes into chip selects. Eight one-hot selects cover eight flash segments of 16 KB each (128 KB in all). One select covers a small window of on-chip control registers, and up to three selects for external devices can be switched on one by one through a parameter. The page register and a mode register sit inside the control window. Software writes and reads them through the same address and strobe pins.

The decode map is fixed by parameters when the design is built. The 256-byte control window has the highest priority, the external windows come next, and the flash area comes last. A segment is picked by the low page bit together with the top two address bits. A page whose upper bits are not zero selects no segment. All selects are registered and appear one clock after the access is presented.

A mode bit chooses how the select register is updated. With turbo set, it reloads on every clock. With turbo clear, it reloads only when the address, the strobes or the page have changed, and a standby flag reports the cycles in which nothing changed.

Top module: `paged_seg_decoder`

## Requirements
- R1: One clock after a read or write strobe in the flash area, with page bits [7:1] zero, seg_sel_o has exactly bit {page[0], addr[15:14]} set.
- R2: seg_sel_o never has more than one bit set.
- R3: An access with addr[15:8] == 0xFF asserts reg_sel_o one clock later, with seg_sel_o and ext_sel_o all zero.
- R4: The page register resets to 0x00. A write at control offset 0x00 loads it from wdata_i, and a read at offset 0x00 returns it on rdata_o in the same cycle. Offset 0x01 holds the turbo bit in bit 0, which also resets to 0. Reads at any other offset, and reads outside the window, return 0x00.
- R5: ext_sel_o[k] is asserted one clock after an access with addr[15:8] equal to 0xFC + k, but only when bit k of the enable mask is set (the default mask is 3'b101). An enabled external window suppresses the segment selects. A disabled external window decodes as flash.
- R6: When page bits [7:1] are not all zero, no segment select is asserted.
- R7: While reset is active, and one clock after a cycle with neither strobe, every select is zero.
- R8: With turbo clear, standby_o rises one clock after a cycle whose address, strobes and page match those of the cycle before, and the selects keep their values. With turbo set, standby_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data for the control registers |
| rdata_o | output | 8 | Read data from the control registers |
| seg_sel_o | output | 8 | One-hot flash segment selects |
| reg_sel_o | output | 1 | Control register window select |
| ext_sel_o | output | 3 | External chip selects |
| standby_o | output | 1 | Decoder held, because no input changed |

## Verification
A wrong page value or a wrong priority shows up at the select outputs one clock after the access that exposes it. It shows as a wrong segment bit, a segment bit next to a register or external select, or a select in a window that should be idle. The bench sweeps every 256-byte address block with both strobes under several page values, in both modes. Every result is compared with the arithmetic decode. A stale held select or a wrong standby flag appears within two clocks of repeating or changing an access.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
  localparam int unsigned PAGE_OFF = 0;
  localparam int unsigned MODE_OFF = 1;
endpackage

// File: rtl/seg_page_regs.sv
module seg_page_regs #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned REG_OFF_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic                 reg_hit_i,
  input  logic [REG_OFF_W-1:0] off_i,
  input  logic [PAGE_W-1:0]    wdata_i,
  output logic [PAGE_W-1:0]    page_o,
  output logic                 turbo_o,
  output logic [PAGE_W-1:0]    rdata_o
);
  import seg_dec_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic              turbo_q;
  logic              wr_page, wr_mode;

  assign wr_page = wr_i && reg_hit_i && (off_i == REG_OFF_W'(PAGE_OFF));
  assign wr_mode = wr_i && reg_hit_i && (off_i == REG_OFF_W'(MODE_OFF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      turbo_q <= 1'b0;
    end else begin
      if (wr_page) page_q  <= wdata_i;
      if (wr_mode) turbo_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && reg_hit_i) begin
      if (off_i == REG_OFF_W'(PAGE_OFF))      rdata_o = page_q;
      else if (off_i == REG_OFF_W'(MODE_OFF)) rdata_o = PAGE_W'(turbo_q);
    end
  end

  assign page_o  = page_q;
  assign turbo_o = turbo_q;

  AST_PAGE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_page |=> (page_q == $past(wdata_i))); // R4
endmodule

// File: rtl/seg_addr_decode.sv
module seg_addr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SEG_W     = 14,
  parameter int unsigned NUM_SEG   = 8,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned REG_OFF_W = 8,
  parameter int unsigned NUM_EXT   = 3,
  parameter logic [ADDR_W-REG_OFF_W-1:0] REG_HI = 8'hFF,
  parameter logic [NUM_EXT*(ADDR_W-REG_OFF_W)-1:0] EXT_HI = {8'hFE, 8'hFD, 8'hFC},
  parameter logic [NUM_EXT-1:0] EXT_EN = 3'b101
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic               strobe_i,
  output logic               reg_hit_o,
  output logic [NUM_SEG-1:0] seg_sel_o,
  output logic               reg_sel_o,
  output logic [NUM_EXT-1:0] ext_sel_o
);
  localparam int unsigned HI_W      = ADDR_W - REG_OFF_W;
  localparam int unsigned IDX_W     = $clog2(NUM_SEG);
  localparam int unsigned ADR_SEL_W = ADDR_W - SEG_W;
  localparam int unsigned PG_SEL_W  = IDX_W - ADR_SEL_W;

  logic [HI_W-1:0]    hi;
  logic [NUM_EXT-1:0] ext_hit;
  logic [IDX_W-1:0]   seg_idx;
  logic               page_ok, flash_ok;

  assign hi        = addr_i[ADDR_W-1:REG_OFF_W];
  assign reg_hit_o = (hi == REG_HI);

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    assign ext_hit[k] = EXT_EN[k] && (hi == EXT_HI[k*HI_W +: HI_W]);
  end

  assign page_ok  = (page_i[PAGE_W-1:PG_SEL_W] == '0);
  assign seg_idx  = {page_i[PG_SEL_W-1:0], addr_i[ADDR_W-1:SEG_W]};
  assign flash_ok = strobe_i && !reg_hit_o && (ext_hit == '0) && page_ok;

  assign seg_sel_o = flash_ok ? (NUM_SEG'(1) << seg_idx) : '0;
  assign reg_sel_o = strobe_i && reg_hit_o;
  assign ext_sel_o = (strobe_i && !reg_hit_o) ? ext_hit : '0;
endmodule

// File: rtl/seg_hold_stage.sv
module seg_hold_stage #(
  parameter int unsigned SEL_W = 12,
  parameter int unsigned IN_W  = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             turbo_i,
  input  logic [IN_W-1:0]  in_vec_i,
  input  logic [SEL_W-1:0] sel_d_i,
  output logic [SEL_W-1:0] sel_q_o,
  output logic             standby_o
);
  logic [IN_W-1:0]  seen_q;
  logic [SEL_W-1:0] sel_q;
  logic             stby_q;
  logic             changed;

  assign changed = (in_vec_i != seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      sel_q  <= '0;
      stby_q <= 1'b0;
    end else begin
      seen_q <= in_vec_i;
      if (turbo_i || changed) sel_q <= sel_d_i;
      stby_q <= !turbo_i && !changed;
    end
  end

  assign sel_q_o   = sel_q;
  assign standby_o = stby_q;

  AST_STANDBY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_q |-> $stable(sel_q)); // R8
  AST_TURBO_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turbo_i |=> !stby_q); // R8
endmodule

// File: rtl/paged_seg_decoder.sv
module paged_seg_decoder #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SEG_W     = 14,
  parameter int unsigned NUM_SEG   = 8,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned REG_OFF_W = 8,
  parameter int unsigned NUM_EXT   = 3,
  parameter logic [ADDR_W-REG_OFF_W-1:0] REG_HI = 8'hFF,
  parameter logic [NUM_EXT*(ADDR_W-REG_OFF_W)-1:0] EXT_HI = {8'hFE, 8'hFD, 8'hFC},
  parameter logic [NUM_EXT-1:0] EXT_EN = 3'b101
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [PAGE_W-1:0]  wdata_i,
  output logic [PAGE_W-1:0]  rdata_o,
  output logic [NUM_SEG-1:0] seg_sel_o,
  output logic               reg_sel_o,
  output logic [NUM_EXT-1:0] ext_sel_o,
  output logic               standby_o
);
  localparam int unsigned SEL_W = NUM_SEG + 1 + NUM_EXT;
  localparam int unsigned IN_W  = ADDR_W + 2 + PAGE_W;

  logic [PAGE_W-1:0]  page;
  logic               turbo, reg_hit, strobe;
  logic [NUM_SEG-1:0] seg_d;
  logic               reg_d;
  logic [NUM_EXT-1:0] ext_d;
  logic [SEL_W-1:0]   sel_q;

  assign strobe = rd_i || wr_i;

  seg_page_regs #(.PAGE_W(PAGE_W), .REG_OFF_W(REG_OFF_W)) u_regs (
    .clk_i, .rst_ni, .rd_i, .wr_i,
    .reg_hit_i(reg_hit),
    .off_i    (addr_i[REG_OFF_W-1:0]),
    .wdata_i,
    .page_o   (page),
    .turbo_o  (turbo),
    .rdata_o
  );

  seg_addr_decode #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .PAGE_W(PAGE_W),
    .REG_OFF_W(REG_OFF_W), .NUM_EXT(NUM_EXT), .REG_HI(REG_HI),
    .EXT_HI(EXT_HI), .EXT_EN(EXT_EN)
  ) u_dec (
    .addr_i, .page_i(page), .strobe_i(strobe),
    .reg_hit_o(reg_hit), .seg_sel_o(seg_d), .reg_sel_o(reg_d), .ext_sel_o(ext_d)
  );

  seg_hold_stage #(.SEL_W(SEL_W), .IN_W(IN_W)) u_hold (
    .clk_i, .rst_ni,
    .turbo_i  (turbo),
    .in_vec_i ({addr_i, rd_i, wr_i, page}),
    .sel_d_i  ({ext_d, reg_d, seg_d}),
    .sel_q_o  (sel_q),
    .standby_o
  );

  assign seg_sel_o = sel_q[NUM_SEG-1:0];
  assign reg_sel_o = sel_q[NUM_SEG];
  assign ext_sel_o = sel_q[SEL_W-1:NUM_SEG+1];

  AST_SEG_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(seg_sel_o)); // R2
  AST_REG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_o |-> (seg_sel_o == '0 && ext_sel_o == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> (seg_sel_o == '0 && !reg_sel_o && ext_sel_o == '0)); // R7
  AST_PAGE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page[PAGE_W-1:1] != '0) |=> (seg_sel_o == '0 || $changed(page))); // R6
endmodule

// File: tb/paged_seg_decoder_bench.sv
module paged_seg_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, seg_sel;
  logic reg_sel, standby;
  logic [2:0] ext_sel;

  int checks = 0;
  int errors = 0;
  logic [7:0] page_m = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_seg_decoder u_paged_seg_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .seg_sel_o(seg_sel), .reg_sel_o(reg_sel),
    .ext_sel_o(ext_sel), .standby_o(standby)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {ext[2:0], reg, seg[7:0]}
  function automatic logic [11:0] exp_sel(input logic [15:0] a, input logic s, input logic [7:0] pg);
    logic [7:0] hi = a[15:8];
    logic [2:0] ext = 3'b000;
    logic [7:0] seg = 8'h00;
    if (!s) return 12'h000;
    if (hi == 8'hFF) return 12'h100;
    if (hi == 8'hFC) ext[0] = 1'b1;
    if (hi == 8'hFE) ext[2] = 1'b1;
    if (ext == 3'b000 && pg[7:1] == 7'd0) seg = 8'h01 << (pg[0]*4 + a[15:14]);
    return {ext, 1'b0, seg};
  endfunction

  task automatic step(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic access_chk(input string req, input logic [15:0] a, input logic r, input logic w);
    logic [11:0] e = exp_sel(a, r | w, page_m);
    step(a, r, w, 8'h00);
    chk(req, {ext_sel, reg_sel, seg_sel}, e);
  endtask

  task automatic set_page(input logic [7:0] p);
    step(16'hFF00, 1'b0, 1'b1, p);
    page_m = p;
  endtask

  task automatic set_turbo(input logic t);
    step(16'hFF01, 1'b0, 1'b1, {7'd0, t});
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset state
    rd = 1'b1; addr = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset selects", {ext_sel, reg_sel, seg_sel}, 12'h000);
    @(negedge clk); rst_n = 1'b1; rd = 1'b0;
    step(16'h0000, 1'b0, 1'b0, 8'h00);

    // R4: reset values read back
    step(16'hFF00, 1'b1, 1'b0, 8'h00);
    chk("R4 page reset", rdata, 8'h00);
    chk("R3 reg select on read", {ext_sel, reg_sel, seg_sel}, 12'h100);
    step(16'hFF01, 1'b1, 1'b0, 8'h00);
    chk("R4 turbo reset", rdata, 8'h00);
    step(16'hFF07, 1'b1, 1'b0, 8'h00);
    chk("R4 unused offset", rdata, 8'h00);

    // R4: page write and read
    set_page(8'hA5);
    step(16'hFF00, 1'b1, 1'b0, 8'h00);
    chk("R4 page readback", rdata, 8'hA5);
    step(16'h1200, 1'b1, 1'b0, 8'h00);
    chk("R4 read outside window", rdata, 8'h00);

    // R1 R2 R3 R5 R6: sweeps over pages, both modes
    for (int m = 0; m < 2; m++) begin
      set_turbo(m[0]);
      step(16'hFF01, 1'b1, 1'b0, 8'h00);
      chk("R4 turbo readback", rdata, {7'd0, m[0]});
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pv = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h02 : 8'h81;
        set_page(pv);
        for (int b = 0; b < 256; b++) begin
          access_chk((pv[7:1] != 0) ? "R6 page gate" : "R1 segment decode",
                     {b[7:0], 8'h3C}, 1'b1, 1'b0);
          if (b[7:0] < 8'hFF)
            access_chk("R5 window decode write", {b[7:0], 8'h10}, 1'b0, 1'b1);
        end
      end
    end

    // R5 specific: disabled window decodes as flash
    set_turbo(1'b1);
    set_page(8'h01);
    access_chk("R5 disabled ext window", 16'hFD00, 1'b1, 1'b0);
    chk("R5 FD to segment 7", seg_sel, 8'h80);
    access_chk("R5 ext0 enabled", 16'hFC80, 1'b1, 1'b0);
    chk("R5 ext0 bit", ext_sel, 3'b001);
    access_chk("R5 ext2 enabled", 16'hFE80, 1'b1, 1'b0);
    chk("R5 ext2 bit", ext_sel, 3'b100);

    // R7: idle after strobe
    access_chk("R1 seg before idle", 16'h4000, 1'b1, 1'b0);
    chk("R1 segment 5", seg_sel, 8'h20);
    access_chk("R7 idle clears", 16'h4000, 1'b0, 1'b0);

    // R8: turbo keeps standby low on repeated input
    access_chk("R8 turbo a", 16'h8000, 1'b1, 1'b0);
    access_chk("R8 turbo b", 16'h8000, 1'b1, 1'b0);
    chk("R8 turbo no standby", standby, 1'b0);

    // R8: non-turbo standby and hold
    set_turbo(1'b0);
    access_chk("R8 change", 16'hC000, 1'b1, 1'b0);
    chk("R8 no standby on change", standby, 1'b0);
    access_chk("R8 hold", 16'hC000, 1'b1, 1'b0);
    chk("R8 standby on repeat", standby, 1'b1);
    chk("R8 held seg", seg_sel, 8'h80);
    access_chk("R8 wake", 16'h0000, 1'b1, 1'b0);
    chk("R8 standby drops", standby, 1'b0);
    chk("R8 updated seg", seg_sel, 8'h10);

    // R8: page change alone wakes decoder
    set_page(8'h00);
    access_chk("R8 after page write", 16'h0000, 1'b1, 1'b0);
    chk("R8 new page seg", seg_sel, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule